// File: doc/BRIEF.md
# Interrupt-Frozen Status Capture

This block holds the values that a bus slave returns when a master reads any of its three read-only status registers. When no interrupt is pending, the block takes a fresh copy of the live status inputs each time the bus engine signals that its read address has been acknowledged. The copy is taken just before the data bytes go out on the bus.

A rising edge on any status bit whose mask bit is set counts as an interrupt event. The event pulls the active-low interrupt output low. In the same cycle it copies all three status registers at once. From then on the copy is frozen, so every read shows the state that caused the interrupt, even if more events arrive. When the master clears the interrupt, the freeze ends. The next copy then comes from whichever happens first: a read-address acknowledge or a new event.

The bus protocol engine lies outside this block. It supplies the acknowledge and clear strobes and serialises the held bytes.

Top module: `stat_capture`

## Requirements
- R1: While reset is active, and in the first cycle after it, `irq_no` is 1 and `stat_held_o` is all zero. Reset also sets the stored previous value of every status bit to 0.
- R2: An event occurs in a cycle when some status bit is 1, its stored previous value is 0 and its mask bit is 1. When that happens, `irq_no` is 0 in the next cycle. A rise on a bit whose mask bit is 0 never drives `irq_no` low.
- R3: When an event occurs and no interrupt is pending, all three held registers load the live status of that cycle together. The new values are visible in the next cycle.
- R4: While an interrupt is pending and no clear arrives, `stat_held_o` does not change. Read acknowledges, changes on the live inputs and further events have no effect on it.
- R5: Once `irq_no` is 0, it stays 0 until a cycle with `irq_clr_i` = 1.
- R6: A clear with no event in the same cycle makes `irq_no` 1 in the next cycle. From then on, reads take snapshots again.
- R7: With no interrupt pending, `rd_ack_i` = 1 loads all three held registers from the live status, visible in the next cycle. A cycle with neither an acknowledge nor an event leaves `stat_held_o` unchanged.
- R8: If a clear and an event fall in the same cycle, the interrupt stays pending (`irq_no` = 0). The held registers are re-latched with that cycle's live status.
- R9: If a clear and a read acknowledge fall in the same cycle, the acknowledge takes a snapshot, because the clear releases the freeze in that same cycle.
- R10: Status register k occupies bits [8k+7:8k] of `stat_live_i` and `stat_held_o`. Each bit of `stat_mask_i` gates the status bit at the same position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stat_live_i | input | 24 | Live status bits, three registers |
| stat_mask_i | input | 24 | Per-bit interrupt enable |
| rd_ack_i | input | 1 | Read-address acknowledge strobe |
| irq_clr_i | input | 1 | Interrupt clear strobe from the master |
| stat_held_o | output | 24 | Held status bytes returned on reads |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The capture is driven three ways:
- Idle read acknowledges with changing live data show that snapshots follow the acknowledge instant.
- Rises on masked and unmasked bits in each register byte show that only enabled rises freeze the data, and that the mask positions line up.
- Stimulus made while an interrupt is pending (acknowledges, new rises, clears on their own, and clears that coincide with an event or an acknowledge) separates freezing from re-latching and releasing.

A long random phase compares every cycle against a behavioural model.

// File: rtl/stat_capture_pkg.sv
`timescale 1ns/1ps
package stat_capture_pkg;
  typedef enum logic [1:0] {
    CAP_HOLD = 2'd0,
    CAP_ACK  = 2'd1,
    CAP_EVT  = 2'd2
  } cap_src_e;
endpackage

// File: rtl/stat_rise_det.sv
`timescale 1ns/1ps
module stat_rise_det #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] mask_i,
  output logic         hit_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= live_i;
  end

  assign hit_o = |(live_i & ~prev_q & mask_i);
endmodule

// File: rtl/stat_irq_ctl.sv
`timescale 1ns/1ps
module stat_irq_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  // event wins over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= evt_i | (pend_q & ~clr_i);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/stat_snap_reg.sv
`timescale 1ns/1ps
module stat_snap_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (load_i) q_q <= d_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/stat_capture.sv
`timescale 1ns/1ps
module stat_capture
  import stat_capture_pkg::*;
#(
  parameter int NUM_REGS = 3,
  parameter int REG_W    = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_REGS*REG_W-1:0] stat_live_i,
  input  logic [NUM_REGS*REG_W-1:0] stat_mask_i,
  input  logic                      rd_ack_i,
  input  logic                      irq_clr_i,
  output logic [NUM_REGS*REG_W-1:0] stat_held_o,
  output logic                      irq_no
);
  localparam int NW = NUM_REGS * REG_W;

  logic [NUM_REGS-1:0] hit;
  logic                evt;
  logic                pend;
  logic                frozen;
  cap_src_e            cap_src;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    stat_rise_det #(.W(REG_W)) u_rise (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .live_i (stat_live_i[k*REG_W +: REG_W]),
      .mask_i (stat_mask_i[k*REG_W +: REG_W]),
      .hit_o  (hit[k])
    );

    stat_snap_reg #(.W(REG_W)) u_snap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (cap_src != CAP_HOLD),
      .d_i    (stat_live_i[k*REG_W +: REG_W]),
      .q_o    (stat_held_o[k*REG_W +: REG_W])
    );
  end

  assign evt = |hit;

  stat_irq_ctl u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .clr_i  (irq_clr_i),
    .pend_o (pend)
  );

  // a clear in this cycle releases the freeze for this cycle's capture
  assign frozen = pend & ~irq_clr_i;

  always_comb begin
    cap_src = CAP_HOLD;
    if (!frozen) begin
      if (evt)           cap_src = CAP_EVT;
      else if (rd_ack_i) cap_src = CAP_ACK;
    end
  end

  assign irq_no = ~pend;

  logic [NW-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/stat_capture_chk.sv
`timescale 1ns/1ps
module stat_capture_chk #(
  parameter int NW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NW-1:0] live_i,
  input logic          ack_i,
  input logic          clr_i,
  input logic          evt_i,
  input logic [NW-1:0] held_i,
  input logic          irq_ni
);
  a_r2_irq_on_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> !irq_ni);

  a_r3_event_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && (irq_ni || clr_i)) |=> (held_i == $past(live_i)));

  a_r4_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_ni && !clr_i) |=> $stable(held_i));

  a_r5_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_ni && !clr_i) |=> !irq_ni);

  a_r6_clear_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt_i) |=> irq_ni);

  a_r7_ack_snapshot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_ni && !evt_i) |=> (held_i == $past(live_i)));

  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_i && !evt_i) |=> $stable(held_i));

  a_r9_clear_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && clr_i && !evt_i) |=> (held_i == $past(live_i)));
endmodule

bind stat_capture stat_capture_chk #(.NW(NUM_REGS*REG_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .live_i (stat_live_i),
  .ack_i  (rd_ack_i),
  .clr_i  (irq_clr_i),
  .evt_i  (evt),
  .held_i (stat_held_o),
  .irq_ni (irq_no)
);

// File: tb/stat_capture_test.sv
`timescale 1ns/1ps
module stat_capture_test;
  localparam int NW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NW-1:0] live = '0;
  logic [NW-1:0] mask = '0;
  logic          ack = 1'b0;
  logic          clr = 1'b0;
  logic [NW-1:0] held;
  logic          irq_n;

  int n_chk = 0;
  int n_err = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // behavioural reference
  bit [NW-1:0] m_prev, m_held;
  bit          m_pend;

  always #2.5 clk = ~clk;

  stat_capture uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .stat_live_i (live),
    .stat_mask_i (mask),
    .rd_ack_i    (ack),
    .irq_clr_i   (clr),
    .stat_held_o (held),
    .irq_no      (irq_n)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = '0; m_held = '0; m_pend = 1'b0;
    end else begin
      bit ev;
      bit frz;
      ev = 1'b0;
      for (int i = 0; i < NW; i++)
        if (live[i] && !m_prev[i] && mask[i]) ev = 1'b1;
      frz = m_pend && !clr;
      if (!frz && (ev || ack)) m_held = live;
      m_pend = ev || (m_pend && !clr);
      m_prev = live;
    end
  end

  task automatic chk(string req, logic [NW-1:0] a_held, logic [NW-1:0] e_held,
                     logic a_irq, logic e_irq);
    n_chk++;
    if (a_held !== e_held || a_irq !== e_irq) begin
      n_err++;
      $display("FAIL %s: held=%h irq_n=%b expected held=%h irq_n=%b",
               req, a_held, a_irq, e_held, e_irq);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // drive, one clock, compare at the falling edge
  task automatic cyc(logic [NW-1:0] l, logic [NW-1:0] m, logic a, logic c);
    live = l; mask = m; ack = a; clr = c;
    @(posedge clk);
    @(negedge clk);
    chk(cur_req, held, m_held, irq_n, !m_pend);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: expired, expected completion");
      report();
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", held, '0, irq_n, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", held, '0, irq_n, 1'b1);

    // R7 idle snapshot and hold
    cur_req = "R7";
    cyc(24'h112233, '0, 1'b1, 1'b0);
    chk("R7", held, 24'h112233, irq_n, 1'b1);
    cyc(24'h445566, '0, 1'b0, 1'b0);
    chk("R7", held, 24'h112233, irq_n, 1'b1);

    // R2 masked rises never raise
    cur_req = "R2";
    cyc(24'h000000, 24'h00FF00, 1'b0, 1'b0);
    cyc(24'hFF00FF, 24'h00FF00, 1'b0, 1'b0);
    chk("R2", held, 24'h112233, irq_n, 1'b1);

    // R3 unmasked rise latches all three
    cur_req = "R3";
    cyc(24'hFF01FF, 24'h00FF00, 1'b0, 1'b0);
    chk("R3", held, 24'hFF01FF, irq_n, 1'b0);

    // R4 frozen against ack, live change, new rise
    cur_req = "R4";
    cyc(24'h0A0BFF, 24'h00FF00, 1'b1, 1'b0);
    cyc(24'h0AFF0C, 24'h00FF00, 1'b1, 1'b0);
    chk("R4", held, 24'hFF01FF, irq_n, 1'b0);

    // R5 stays low
    cur_req = "R5";
    for (int i = 0; i < 4; i++) cyc(24'h000000, 24'h00FF00, 1'b0, 1'b0);
    chk("R5", held, 24'hFF01FF, irq_n, 1'b0);

    // R6 clear releases, then snapshot again
    cur_req = "R6";
    cyc(24'h000000, 24'h00FF00, 1'b0, 1'b1);
    chk("R6", held, 24'hFF01FF, irq_n, 1'b1);
    cyc(24'h123400, 24'h00FF00, 1'b1, 1'b0);
    chk("R6", held, 24'h123400, irq_n, 1'b0);

    // R8 clear with event: still pending, re-latched
    cur_req = "R8";
    cyc(24'h000000, 24'h00FF00, 1'b0, 1'b0);
    cyc(24'h770100, 24'h00FF00, 1'b0, 1'b1);
    chk("R8", held, 24'h770100, irq_n, 1'b0);

    // R9 clear with ack: snapshot taken
    cur_req = "R9";
    cyc(24'h5A5A5A & 24'hFF00FF, 24'h00FF00, 1'b1, 1'b1);
    chk("R9", held, 24'h5A005A, irq_n, 1'b1);

    // R10 bit positions of mask and registers
    cur_req = "R10";
    cyc(24'h000000, 24'h020000, 1'b0, 1'b0);
    cyc(24'h000200, 24'h020000, 1'b0, 1'b0);
    chk("R10", held, 24'h5A005A, irq_n, 1'b1);
    cyc(24'h020200, 24'h020000, 1'b0, 1'b0);
    chk("R10", held, 24'h020200, irq_n, 1'b0);
    cyc(24'h000000, 24'h020000, 1'b0, 1'b1);
    chk("R10", held, 24'h020200, irq_n, 1'b1);

    // random comparison against the model, all requirements
    cur_req = "R2-R9 random (R4 R8)";
    for (int i = 0; i < 2000; i++)
      cyc(NW'($urandom) & NW'($urandom), NW'($urandom),
          ($urandom % 4) == 0, ($urandom % 6) == 0);

    done = 1'b1;
    report();
  end
endmodule